// File: doc/BRIEF.md
# Isochronous Resource Compare-Swap Register Unit

This block keeps the four shared resource registers that nodes on a serial bus compete for. They are the bus manager identity, the remaining isochronous bandwidth, and the upper and lower halves of the free-channel mask. An upstream parser delivers decoded quadlet requests, each with a 48-bit offset, a transaction kind, a compare argument and a data value. The block answers one cycle later with a response code and the quadlet that was in the register before the request. Compare-swap is atomic. The old value is always returned, and the new data lands only when the old value matches the argument.

A local host write port lets software reload any register, for example after a bus reset. A host write can arrive in the same cycle as an accepted remote request. In that case the remote operation completes first. The host write is held for one cycle and committed while remote requests are stalled, so no remote read-compare-write can be split by a local update.

The control is a three-state machine. ST_IDLE means no response is pending. ST_REPLY means a response is being presented. ST_DEFER means a response is being presented and a held host write is being committed. The transitions are:
- accept-alone, from ST_IDLE or ST_REPLY to ST_REPLY.
- accept-with-host, from ST_IDLE or ST_REPLY to ST_DEFER.
- quiet, from ST_IDLE or ST_REPLY to ST_IDLE.
- drain, from ST_DEFER to ST_IDLE, taken unconditionally.

Top module: `irm_cswap_unit`

## Requirements
- R1: After reset the registers hold bus manager ID 0000003Fh, bandwidth 00001333h, channels high FFFFFFFFh and channels low FFFFFFFFh.
- R2: The register index is selected by offset. 0xFFFFF000021C is the bus manager ID (host_sel 0). 0xFFFFF0000220 is the bandwidth (host_sel 1). 0xFFFFF0000224 is channels high (host_sel 2). 0xFFFFF0000228 is channels low (host_sel 3).
- R3: A quadlet read (req_kind 0) to a mapped offset answers code 0 (complete) with the current value, and it leaves the register unchanged.
- R4: A compare-swap (req_kind 4) answers code 0 with the old value, and it stores req_data when the old value equals req_arg.
- R5: A compare-swap whose req_arg differs from the old value leaves the register unchanged.
- R6: Every other kind sent to a mapped offset answers code 1 (type error) with data 0 and changes nothing. These kinds are 1 quadlet write, 2 block read, 3 block write and 5 other lock.
- R7: An offset that is not one of the four aligned addresses answers code 2 (address error) with data 0.
- R8: resp_valid is high exactly in the cycle after an accepted request (req_valid and req_ready both high), and it is low otherwise, including right after reset.
- R9: A host write with no remote request accepted in that cycle updates the register selected by host_sel at that edge.
- R10: When a host write coincides with an accepted request, the remote operation uses the pre-write value. req_ready is low for the next cycle, in which the held host write is committed, and it is high again the cycle after.
- R11: A new host write issued during that stalled cycle to the same register overrides the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Remote request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_offset | input | 48 | Request offset |
| req_kind | input | 3 | Transaction kind code |
| req_arg | input | 32 | Compare argument |
| req_data | input | 32 | Swap data |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register index |
| host_wdata | input | 32 | Host write value |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| resp_data | output | 32 | Old register value, or 0 on error |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- the single stalled cycle that follows a collision;
- the zero data on error responses;
- the fact that reads, mismatched swaps and rejected kinds leave every register untouched;
- the commit of swap data on a match.

The reset values, the exact address mapping and the ordering of a collision can only be shown by the bench's scenarios. The ordering covers the lock seeing the old value, the host value winning afterward, and a later host write overriding the held one.

// File: rtl/irm_pkg.sv
package irm_pkg;
    typedef enum logic [2:0] {
        KIND_QREAD      = 3'd0,
        KIND_QWRITE     = 3'd1,
        KIND_BREAD      = 3'd2,
        KIND_BWRITE     = 3'd3,
        KIND_CSWAP      = 3'd4,
        KIND_LOCK_OTHER = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        RESP_COMPLETE = 2'd0,
        RESP_TYPE_ERR = 2'd1,
        RESP_ADDR_ERR = 2'd2
    } resp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REPLY = 2'd1,
        ST_DEFER = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/irm_addr_decode.sv
module irm_addr_decode #(
    parameter int unsigned OFFS_W   = 48,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS),
    parameter logic [OFFS_W-1:0] BASE = 48'hFFFF_F000_021C
) (
    input  logic [OFFS_W-1:0] offset,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned SPAN_LSB = IDX_W + 2;

    logic [OFFS_W-1:0] delta;

    always_comb begin
        delta = offset - BASE;
        hit   = (delta[OFFS_W-1:SPAN_LSB] == '0) && (delta[1:0] == 2'b00);
        idx   = delta[SPAN_LSB-1:2];
    end
endmodule

// File: rtl/irm_regbank.sv
module irm_regbank #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS),
    parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              a_we,
    input  logic [IDX_W-1:0]                  a_idx,
    input  logic [DATA_W-1:0]                 a_wdata,
    input  logic                              b_we,
    input  logic [IDX_W-1:0]                  b_idx,
    input  logic [DATA_W-1:0]                 b_wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    // Port b has priority over port a when both target one entry.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= RST_VALS[g*DATA_W +: DATA_W];
            end else if (b_we && (b_idx == IDX_W'(g))) begin
                regs[g] <= b_wdata;
            end else if (a_we && (a_idx == IDX_W'(g))) begin
                regs[g] <= a_wdata;
            end
        end
    end
endmodule

// File: rtl/irm_cswap_unit.sv
module irm_cswap_unit
    import irm_pkg::*;
#(
    parameter int unsigned OFFS_W   = 48,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4,
    parameter logic [OFFS_W-1:0] BASE_OFFS = 48'hFFFF_F000_021C,
    parameter logic [DATA_W-1:0] RST_BUSMGR = 32'h0000_003F,
    parameter logic [DATA_W-1:0] RST_BANDW  = 32'h0000_1333,
    parameter logic [DATA_W-1:0] RST_CHHI   = 32'hFFFF_FFFF,
    parameter logic [DATA_W-1:0] RST_CHLO   = 32'hFFFF_FFFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [OFFS_W-1:0]           req_offset,
    input  logic [2:0]                  req_kind,
    input  logic [DATA_W-1:0]           req_arg,
    input  logic [DATA_W-1:0]           req_data,
    input  logic                        host_we,
    input  logic [$clog2(NUM_REGS)-1:0] host_sel,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic                        resp_valid,
    output logic [1:0]                  resp_code,
    output logic [DATA_W-1:0]           resp_data
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);
    localparam logic [NUM_REGS*DATA_W-1:0] RST_VALS =
        {RST_CHLO, RST_CHHI, RST_BANDW, RST_BUSMGR};

    ctl_state_e state_q, state_d;

    logic                              accept;
    logic                              dec_hit;
    logic [IDX_W-1:0]                  dec_idx;
    logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q;
    logic [DATA_W-1:0]                 old_val;
    logic                              is_read, is_cswap, swap_hit;
    logic                              a_we, b_we;
    logic [IDX_W-1:0]                  a_idx;
    logic [DATA_W-1:0]                 a_wdata;
    logic [IDX_W-1:0]                  pend_idx_q;
    logic [DATA_W-1:0]                 pend_data_q;
    logic [1:0]                        code_q;
    logic [DATA_W-1:0]                 data_q;

    irm_addr_decode #(
        .OFFS_W(OFFS_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BASE(BASE_OFFS)
    ) u_dec (
        .offset(req_offset), .hit(dec_hit), .idx(dec_idx)
    );

    irm_regbank #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_VALS(RST_VALS)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_we), .a_idx(a_idx), .a_wdata(a_wdata),
        .b_we(b_we), .b_idx(host_sel), .b_wdata(host_wdata),
        .regs(regs_q)
    );

    assign req_ready = (state_q != ST_DEFER);
    assign accept    = req_valid && req_ready;
    assign old_val   = regs_q[dec_idx];
    assign is_read   = (req_kind == KIND_QREAD);
    assign is_cswap  = (req_kind == KIND_CSWAP);
    assign swap_hit  = accept && dec_hit && is_cswap && (old_val == req_arg);

    // Port a: remote swap, or held host write while stalled.
    always_comb begin
        a_we    = swap_hit || (state_q == ST_DEFER);
        a_idx   = (state_q == ST_DEFER) ? pend_idx_q  : dec_idx;
        a_wdata = (state_q == ST_DEFER) ? pend_data_q : req_data;
    end
    // Port b: host write applied at once unless a remote request is accepted.
    assign b_we = host_we && !accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REPLY: begin
                if (accept && host_we) state_d = ST_DEFER;
                else if (accept)       state_d = ST_REPLY;
                else                   state_d = ST_IDLE;
            end
            ST_DEFER: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q      <= RESP_COMPLETE;
            data_q      <= '0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else begin
            if (accept) begin
                if (!dec_hit) begin
                    code_q <= RESP_ADDR_ERR;
                    data_q <= '0;
                end else if (is_read || is_cswap) begin
                    code_q <= RESP_COMPLETE;
                    data_q <= old_val;
                end else begin
                    code_q <= RESP_TYPE_ERR;
                    data_q <= '0;
                end
            end
            if (accept && host_we) begin
                pend_idx_q  <= host_sel;
                pend_data_q <= host_wdata;
            end
        end
    end

    assign resp_valid = (state_q != ST_IDLE);
    assign resp_code  = code_q;
    assign resp_data  = data_q;
endmodule

// File: rtl/irm_cswap_sva.sv
module irm_cswap_sva
    import irm_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic                             req_ready,
    input logic [2:0]                       req_kind,
    input logic [DATA_W-1:0]                req_arg,
    input logic [DATA_W-1:0]                req_data,
    input logic                             host_we,
    input logic                             resp_valid,
    input logic [1:0]                       resp_code,
    input logic [DATA_W-1:0]                resp_data,
    input logic                             dec_hit,
    input logic [IDX_W-1:0]                 dec_idx,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r8_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> resp_valid);
    a_r8_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !resp_valid);
    a_r10_stall_after_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_we) |=> !req_ready);
    a_r10_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);
    a_r6_error_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code != RESP_COMPLETE) |-> (resp_data == '0));
    a_r3_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == KIND_QREAD && !host_we) |=> (regs == $past(regs)));
    a_r4_swap_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_hit && req_kind == KIND_CSWAP && regs[dec_idx] == req_arg)
        |=> (regs[$past(dec_idx)] == $past(req_data)));
    a_r4_old_value_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_hit && (req_kind == KIND_CSWAP || req_kind == KIND_QREAD))
        |=> (resp_code == RESP_COMPLETE && resp_data == $past(regs[dec_idx])));
    a_r5_mismatch_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == KIND_CSWAP && regs[dec_idx] != req_arg && !host_we)
        |=> (regs == $past(regs)));
    a_r6_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind != KIND_CSWAP && req_kind != KIND_QREAD && !host_we)
        |=> (regs == $past(regs)));
endmodule

bind irm_cswap_unit irm_cswap_sva #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_arg(req_arg), .req_data(req_data),
    .host_we(host_we), .resp_valid(resp_valid), .resp_code(resp_code),
    .resp_data(resp_data), .dec_hit(dec_hit), .dec_idx(dec_idx), .regs(regs_q)
);

// File: tb/test_irm_cswap_unit.sv
module test_irm_cswap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;
    localparam logic [47:0] A_BM = 48'hFFFF_F000_021C;
    localparam logic [47:0] A_BW = 48'hFFFF_F000_0220;
    localparam logic [47:0] A_HI = 48'hFFFF_F000_0224;
    localparam logic [47:0] A_LO = 48'hFFFF_F000_0228;

    typedef struct packed {
        logic [2:0]  kind;
        logic [47:0] off;
        logic [31:0] arg;
        logic [31:0] dat;
        logic [1:0]  ecode;
        logic [31:0] edata;
    } vec_t;

    // kinds: 0 read, 1 qwrite, 2 bread, 3 bwrite, 4 cswap, 5 other lock
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, A_BM, 32'h0, 32'h0, 2'd0, 32'h0000_003F},          // R1 R2
        '{3'd0, A_BW, 32'h0, 32'h0, 2'd0, 32'h0000_1333},          // R1 R2
        '{3'd0, A_HI, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFF},          // R1 R2
        '{3'd0, A_LO, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFF},          // R1 R2
        '{3'd4, A_BW, 32'h1333, 32'h1000, 2'd0, 32'h0000_1333},    // R4 match
        '{3'd0, A_BW, 32'h0, 32'h0, 2'd0, 32'h0000_1000},          // R4 stored
        '{3'd4, A_BW, 32'h1333, 32'h0, 2'd0, 32'h0000_1000},       // R5 mismatch
        '{3'd0, A_BW, 32'h0, 32'h0, 2'd0, 32'h0000_1000},          // R5 unchanged
        '{3'd1, A_BM, 32'h0, 32'h5, 2'd1, 32'h0},                  // R6 qwrite
        '{3'd0, A_BM, 32'h0, 32'h0, 2'd0, 32'h0000_003F},          // R6 unchanged
        '{3'd2, A_HI, 32'h0, 32'h0, 2'd1, 32'h0},                  // R6 bread
        '{3'd5, A_LO, 32'hFFFF_FFFF, 32'h0, 2'd1, 32'h0},          // R6 other lock
        '{3'd0, 48'hFFFF_F000_022C, 32'h0, 32'h0, 2'd2, 32'h0},    // R7 above
        '{3'd0, 48'hFFFF_F000_0218, 32'h0, 32'h0, 2'd2, 32'h0},    // R7 below
        '{3'd0, 48'hFFFF_F000_021E, 32'h0, 32'h0, 2'd2, 32'h0},    // R7 misaligned
        '{3'd4, A_BM, 32'h3F, 32'h2, 2'd0, 32'h0000_003F},         // R4 bus mgr
        '{3'd0, A_BM, 32'h0, 32'h0, 2'd0, 32'h0000_0002}           // R3 read back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_offset = '0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_arg = '0;
    logic [31:0] req_data = '0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [31:0] resp_data;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irm_cswap_unit i_irm_cswap_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_kind(req_kind), .req_arg(req_arg),
        .req_data(req_data), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_data(resp_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, accept at posedge, sample at following negedge.
    task automatic remote(input logic [2:0] k, input logic [47:0] o,
                          input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_kind = k; req_offset = o; req_arg = a; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 resp_valid in reset", {31'b0, resp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 resp_valid after reset", {31'b0, resp_valid}, 32'd0);
        chk("R10 ready after reset", {31'b0, req_ready}, 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            remote(VECS[i].kind, VECS[i].off, VECS[i].arg, VECS[i].dat);
            chk($sformatf("R8 valid vec%0d", i), {31'b0, resp_valid}, 32'd1);
            chk($sformatf("R3/R4/R6/R7 code vec%0d", i), {30'b0, resp_code},
                {30'b0, VECS[i].ecode});
            chk($sformatf("R1/R2/R4/R5 data vec%0d", i), resp_data, VECS[i].edata);
        end
        @(negedge clk);
        chk("R8 idle after response", {31'b0, resp_valid}, 32'd0);

        // R9: host write alone
        host_we = 1'b1; host_sel = 2'd3; host_wdata = 32'h0000_0F0F;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
        chk("R9 no response for host write", {31'b0, resp_valid}, 32'd0);
        remote(3'd0, A_LO, 0, 0);
        chk("R9 host value read", resp_data, 32'h0000_0F0F);

        // R10: collision, lock sees old value, host commits after
        host_we = 1'b1; host_sel = 2'd2; host_wdata = 32'h0000_5555;
        remote(3'd4, A_HI, 32'hFFFF_FFFF, 32'h0000_AAAA);
        host_we = 1'b0;
        chk("R10 lock old value", resp_data, 32'hFFFF_FFFF);
        chk("R10 ready low in defer", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R10 ready restored", {31'b0, req_ready}, 32'd1);
        remote(3'd0, A_HI, 0, 0);
        chk("R10 host write lands last", resp_data, 32'h0000_5555);

        // R11: new host write during stall overrides held one
        host_we = 1'b1; host_sel = 2'd2; host_wdata = 32'h0000_1111;
        remote(3'd4, A_HI, 32'h0000_5555, 32'h0000_2222);
        chk("R11 lock old value", resp_data, 32'h0000_5555);
        host_wdata = 32'h0000_7777;
        @(negedge clk);
        host_we = 1'b0;
        remote(3'd0, A_HI, 0, 0);
        chk("R11 later host write wins", resp_data, 32'h0000_7777);

        // R5 on channels low after host update
        remote(3'd4, A_LO, 32'h0, 32'h1234);
        chk("R5 mismatch returns old", resp_data, 32'h0000_0F0F);
        remote(3'd0, A_LO, 0, 0);
        chk("R5 channels low unchanged", resp_data, 32'h0000_0F0F);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule